// File: doc/BRIEF.md
# Sequential Buffer Window Port

This block lets a host reach an internal packet buffer one 16-bit word at a time through a single data register. Software first programs a window register with a starting byte offset and a byte count. Every later access to the data register moves one word and steps the offset forward by two bytes. The access is a write when the host writes the data register and a read when it reads it. Once the last word of the window has moved, a sticky end-of-transfer flag is raised. Software clears that flag by writing a one to it.

A counter-enable bit in a small DMA configuration register stops the window while it is set. In that state, data-register accesses leave the buffer and the pointer untouched. The buffer holds `BUF_BYTES` bytes, 4096 by default, and is kept as an internal word array.

Register map (2-bit `bus_addr`): 0 = window, 1 = data, 2 = status, 3 = DMA configuration.

Top module: `dba_port`

## Requirements
- R1: After reset, `irq_eot` is 0 and `bus_rdata` is 0. A read of the window, status or DMA configuration register returns 0.
- R2: A write to the window register loads the byte offset from `bus_wdata[15:0]` and the byte count from `bus_wdata[31:16]`. A read of the window register returns the remaining word count in bits 31:16 and the current byte pointer in bits 15:0.
- R3: While the window is live and the counter-enable bit is clear, each data-register access moves one word at the pointer. A write stores `bus_wdata[15:0]`. A read returns the word in `bus_rdata[15:0]` one clock after the read cycle. Each access adds 2 to the pointer and subtracts 1 from the remaining word count.
- R4: An odd byte count is rounded up to the next even count. A count of 5 therefore moves 3 words.
- R5: The access that takes the remaining count from 1 to 0 sets the end-of-transfer flag. The flag is bit 3 of the status register and also drives `irq_eot`. Loading the window, including with a count of 0, never sets the flag.
- R6: Writing the status register with bit 3 set clears the flag. A write with bit 3 clear leaves the flag unchanged.
- R7: The DMA configuration register stores `bus_wdata[7:0]` and reads it back. While its bit 7 (counter enable) is 1, data-register accesses leave the buffer, the pointer and the count unchanged, and data reads return 0.
- R8: Data-register accesses made while the remaining count is 0 change nothing, and data reads then return 0.
- R9: A window write made while a transfer is in progress replaces the pointer and the count at once and does not raise the flag.
- R10: The loaded offset is taken modulo `BUF_BYTES` with bit 0 forced to 0. The pointer wraps from the last word of the buffer to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_eot | output | 1 | End-of-transfer flag |

## Verification
The bench builds the port with `BUF_BYTES` set to 64, so the 32-word buffer is small. With this size, a window that starts at byte 62 crosses the top of the buffer after a single word. An offset with bits above the buffer range shows that those bits are discarded. The same small buffer lets the bench keep a word-by-word model of every location it writes. That model lets it confirm that gated, exhausted or aborted accesses left earlier contents intact.

// File: rtl/dba_pkg.sv
package dba_pkg;

  localparam int REG_AW    = 2;
  localparam int BUS_W     = 32;
  localparam int CNT_W     = 16;
  localparam int DMACFG_W  = 8;
  localparam int EOT_BIT   = 3;
  localparam int CTR_EN_BIT = 7;

  typedef enum logic [REG_AW-1:0] {
    REG_WINDOW = 2'd0,
    REG_DATA   = 2'd1,
    REG_STATUS = 2'd2,
    REG_DMACFG = 2'd3
  } dba_reg_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_REG  = 2'd1,
    SRC_BUF  = 2'd2
  } dba_src_e;

  // byte count rounded up to whole 16-bit words
  function automatic logic [CNT_W-1:0] words_for_bytes(input logic [15:0] nbytes);
    logic [16:0] wide;
    wide = ({1'b0, nbytes} + 17'd1) >> 1;
    return wide[CNT_W-1:0];
  endfunction

  // next byte pointer inside a buffer of 2**aw bytes
  function automatic logic [15:0] step_ptr(input logic [15:0] ptr, input int aw);
    logic [15:0] mask;
    mask = 16'((17'd1 << aw) - 17'd1);
    return (ptr + 16'd2) & mask;
  endfunction

endpackage

// File: rtl/dba_window.sv
module dba_window
  import dba_pkg::*;
#(
  parameter int BYTE_AW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [15:0]        load_off,
  input  logic [15:0]        load_cnt,
  input  logic               step,
  output logic [BYTE_AW-1:0] ptr,
  output logic [CNT_W-1:0]   rem,
  output logic               live,
  output logic               done
);

  logic [15:0] ptr_next;

  assign live     = (rem != '0);
  assign done     = step && live && (rem == CNT_W'(1));
  assign ptr_next = step_ptr(16'(ptr), BYTE_AW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      rem <= '0;
    end else if (load) begin
      ptr <= {load_off[BYTE_AW-1:1], 1'b0};
      rem <= words_for_bytes(load_cnt);
    end else if (step && live) begin
      ptr <= ptr_next[BYTE_AW-1:0];
      rem <= rem - CNT_W'(1);
    end
  end

  // each accepted step consumes exactly one word of the count
  assert_step_consumes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && live && !load) |=> (rem == $past(rem) - CNT_W'(1)));

endmodule

// File: rtl/dba_buffer.sv
module dba_buffer #(
  parameter int WORD_AW = 11,
  parameter int LANES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [WORD_AW-1:0]   idx,
  input  logic [8*LANES-1:0]   wdata,
  output logic [8*LANES-1:0]   rdata
);

  localparam int DEPTH = 1 << WORD_AW;

  // one byte-wide array per lane; lane 0 holds the lower byte address
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (wr_en) mem[idx] <= wdata[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (rd_en) q <= mem[idx];
    end

    assign rdata[8*g +: 8] = q;
  end

endmodule

// File: rtl/dba_eot.sv
module dba_eot (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

  assert_set_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

endmodule

// File: rtl/dba_port.sv
module dba_port
  import dba_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_eot
);

  localparam int BYTE_AW = $clog2(BUF_BYTES);
  localparam int WORD_AW = BYTE_AW - 1;
  localparam int LANES   = DATA_W / 8;

  dba_reg_e reg_sel;
  logic wr_cycle, rd_cycle;
  logic hit_window, hit_data, hit_status, hit_dmacfg;
  logic data_acc, ctr_en, go;
  logic win_load, win_live, win_done;
  logic eot_clr;
  logic [BYTE_AW-1:0]  win_ptr;
  logic [CNT_W-1:0]    win_rem;
  logic [DATA_W-1:0]   buf_q;
  logic [DMACFG_W-1:0] dma_cfg;
  logic [BUS_W-1:0]    reg_q;
  dba_src_e            src_q;

  assign reg_sel    = dba_reg_e'(bus_addr);
  assign wr_cycle   = bus_req && bus_we;
  assign rd_cycle   = bus_req && !bus_we;
  assign hit_window = (reg_sel == REG_WINDOW);
  assign hit_data   = (reg_sel == REG_DATA);
  assign hit_status = (reg_sel == REG_STATUS);
  assign hit_dmacfg = (reg_sel == REG_DMACFG);

  assign ctr_en   = dma_cfg[CTR_EN_BIT];
  assign data_acc = bus_req && hit_data;
  assign go       = data_acc && !ctr_en && win_live;
  assign win_load = wr_cycle && hit_window;
  assign eot_clr  = wr_cycle && hit_status && bus_wdata[EOT_BIT];

  dba_window #(.BYTE_AW(BYTE_AW)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (win_load),
    .load_off (bus_wdata[15:0]),
    .load_cnt (bus_wdata[31:16]),
    .step     (go),
    .ptr      (win_ptr),
    .rem      (win_rem),
    .live     (win_live),
    .done     (win_done)
  );

  dba_buffer #(.WORD_AW(WORD_AW), .LANES(LANES)) u_buffer (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (go && bus_we),
    .rd_en (go && !bus_we),
    .idx   (win_ptr[BYTE_AW-1:1]),
    .wdata (bus_wdata[DATA_W-1:0]),
    .rdata (buf_q)
  );

  dba_eot u_eot (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (win_done),
    .clr   (eot_clr),
    .flag  (irq_eot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_cfg <= '0;
    else if (wr_cycle && hit_dmacfg) dma_cfg <= bus_wdata[DMACFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_ZERO;
      reg_q <= '0;
    end else if (rd_cycle) begin
      unique case (reg_sel)
        REG_WINDOW: begin
          src_q <= SRC_REG;
          reg_q <= {16'(win_rem), 16'(win_ptr)};
        end
        REG_DATA:   src_q <= go ? SRC_BUF : SRC_ZERO;
        REG_STATUS: begin
          src_q <= SRC_REG;
          reg_q <= BUS_W'(irq_eot) << EOT_BIT;
        end
        default: begin
          src_q <= SRC_REG;
          reg_q <= BUS_W'(dma_cfg);
        end
      endcase
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_BUF: bus_rdata = BUS_W'(buf_q);
      SRC_REG: bus_rdata = reg_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_done_raises_eot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> irq_eot);

  assert_gate_freezes_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ctr_en) |=> $stable(win_ptr));

  assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cycle && hit_data && !win_live) |=> (bus_rdata == '0));

  assert_load_no_eot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_load && !irq_eot) |=> !irq_eot);

endmodule

// File: tb/dba_port_test.sv
module dba_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUF = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_eot;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dba_port #(.BUF_BYTES(BUF)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_eot(irq_eot)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_win(input logic [15:0] off, input logic [15:0] cnt);
    wr(2'd0, {cnt, off});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 irq after reset", 32'(irq_eot), 32'h0);
    rd(2'd0, v); chk("R1 window reset", v, 32'h0);
    rd(2'd2, v); chk("R1 status reset", v, 32'h0);
    rd(2'd3, v); chk("R1 dmacfg reset", v, 32'h0);
  endtask

  task automatic t_load;
    logic [31:0] v;
    set_win(16'd8, 16'd10);
    rd(2'd0, v); chk("R2 window readback", v, {16'd5, 16'd8});
    set_win(16'd9, 16'd7);
    rd(2'd0, v); chk("R4 R10 odd count and offset", v, {16'd4, 16'd8});
    set_win(16'h0106, 16'd2);
    rd(2'd0, v); chk("R10 offset modulo buffer", v, {16'd1, 16'd6});
    set_win(16'd0, 16'd0);
    rd(2'd0, v); chk("R2 zero window", v, 32'h0);
    rd(2'd2, v); chk("R5 no eot on load", v, 32'h0);
  endtask

  task automatic t_stream;
    logic [31:0] v;
    set_win(16'd4, 16'd6);
    wr(2'd1, 32'h0000_A1B2);
    wr(2'd1, 32'h0000_C3D4);
    chk("R5 irq low before last word", 32'(irq_eot), 32'h0);
    wr(2'd1, 32'h0000_E5F6);
    chk("R5 irq after last word", 32'(irq_eot), 32'h1);
    rd(2'd0, v); chk("R3 pointer and count after writes", v, {16'd0, 16'd10});
    rd(2'd2, v); chk("R5 status bit 3", v, 32'h8);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R6 zero write keeps flag", v, 32'h8);
    wr(2'd2, 32'hFFFF_FFF7);
    rd(2'd2, v); chk("R6 other bits keep flag", v, 32'h8);
    wr(2'd2, 32'h8);
    rd(2'd2, v); chk("R6 w1c clears", v, 32'h0);
    chk("R6 irq cleared", 32'(irq_eot), 32'h0);
    set_win(16'd4, 16'd6);
    rd(2'd1, v); chk("R3 read word 0", v, 32'h0000_A1B2);
    rd(2'd1, v); chk("R3 read word 1", v, 32'h0000_C3D4);
    rd(2'd1, v); chk("R3 read word 2", v, 32'h0000_E5F6);
    chk("R5 irq after read stream", 32'(irq_eot), 32'h1);
    wr(2'd2, 32'h8);
  endtask

  task automatic t_odd;
    logic [31:0] v;
    set_win(16'd26, 16'd2);
    wr(2'd1, 32'h0000_7777);
    wr(2'd2, 32'h8);
    set_win(16'd20, 16'd5);
    wr(2'd1, 32'h0000_1111);
    wr(2'd1, 32'h0000_2222);
    wr(2'd1, 32'h0000_3333);
    wr(2'd1, 32'h0000_4444);
    rd(2'd0, v); chk("R4 R8 three words then stop", v, {16'd0, 16'd26});
    wr(2'd2, 32'h8);
    set_win(16'd20, 16'd5);
    rd(2'd1, v); chk("R4 word 0", v, 32'h1111);
    rd(2'd1, v); chk("R4 word 1", v, 32'h2222);
    rd(2'd1, v); chk("R4 padded word 2", v, 32'h3333);
    rd(2'd1, v); chk("R8 read after end is zero", v, 32'h0);
    wr(2'd2, 32'h8);
    set_win(16'd26, 16'd2);
    rd(2'd1, v); chk("R8 ignored write left buffer", v, 32'h7777);
    wr(2'd2, 32'h8);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    wr(2'd3, 32'h80);
    rd(2'd3, v); chk("R7 dmacfg readback", v, 32'h80);
    set_win(16'd4, 16'd2);
    wr(2'd1, 32'h0000_DEAD);
    rd(2'd0, v); chk("R7 gated write keeps window", v, {16'd1, 16'd4});
    rd(2'd1, v); chk("R7 gated read is zero", v, 32'h0);
    rd(2'd2, v); chk("R7 no eot while gated", v, 32'h0);
    wr(2'd3, 32'h00);
    rd(2'd1, v); chk("R7 buffer unchanged by gated write", v, 32'h0000_A1B2);
    chk("R7 eot after ungated read", 32'(irq_eot), 32'h1);
    wr(2'd2, 32'h8);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    set_win(16'd40, 16'd8);
    wr(2'd1, 32'h0000_0F0F);
    set_win(16'd44, 16'd2);
    rd(2'd0, v); chk("R9 reload mid transfer", v, {16'd1, 16'd44});
    rd(2'd2, v); chk("R9 no eot on abort", v, 32'h0);
    wr(2'd1, 32'h0000_3C3C);
    chk("R9 eot after new window", 32'(irq_eot), 32'h1);
    wr(2'd2, 32'h8);
    set_win(16'd40, 16'd2);
    rd(2'd1, v); chk("R9 word before abort kept", v, 32'h0F0F);
    set_win(16'd44, 16'd2);
    rd(2'd1, v); chk("R9 word after reload", v, 32'h3C3C);
    wr(2'd2, 32'h8);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    set_win(16'(BUF - 2), 16'd4);
    wr(2'd1, 32'h0000_AAAA);
    wr(2'd1, 32'h0000_BBBB);
    rd(2'd0, v); chk("R10 pointer wrapped", v, {16'd0, 16'd2});
    set_win(16'd0, 16'd2);
    rd(2'd1, v); chk("R10 wrapped word at 0", v, 32'hBBBB);
    set_win(16'(BUF - 2), 16'd2);
    rd(2'd1, v); chk("R10 top word", v, 32'hAAAA);
    wr(2'd2, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_stream();
    t_odd();
    t_gate();
    t_abort();
    t_wrap();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule